// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs the integer multiply and divide operations of a 32-bit RISC datapath. It keeps its results in two dedicated registers, HI and LO, instead of the general register file. A multiply writes the upper half of its 64-bit product to HI and the lower half to LO. A divide writes the quotient to LO and the remainder to HI. The pipeline can also copy an operand straight into HI or LO, and it can read either register onto a result bus, from where the value is written back to a general register.

The pipeline issues a 3-bit command each cycle along with two 32-bit operands. Multiply and divide are iterative and take 32 cycles. They use an unsigned shift-add or restoring shift-subtract core, with a sign correction wrapped around it. While an operation runs, `busy` is high. The pipeline holds any read until `busy` falls, and the unit ignores any command issued in that window.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO hold zero, `busy` is low and `result` is zero.
- R2: When `busy` is low, command 3 loads `op_a` into LO and command 4 loads `op_a` into HI, both at the next clock edge.
- R3: When `busy` is low, command 1 drives LO and command 2 drives HI onto `result` in the same cycle. Every other command, including 0 (idle), gives `result` = 0.
- R4: When `busy` is low, command 5 (multiply), 6 (unsigned divide) or 7 (signed divide) is accepted at the clock edge. `busy` is then high for exactly 32 cycles, and HI and LO take the new values at the edge where `busy` falls.
- R5: Multiply writes the 64-bit product of `op_a` and `op_b` as HI:LO. The operands are two's complement when `mul_signed` is 1 and unsigned when it is 0. The value of `mul_signed` is sampled when the command is accepted.
- R6: Unsigned divide writes `op_a / op_b` to LO and `op_a % op_b` to HI, with both operands unsigned.
- R7: Signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend. The case -2^31 / -1 gives LO = 0x80000000 and HI = 0.
- R8: A divide by zero completes without a trap. An unsigned divide by zero gives LO = 0xFFFFFFFF and HI = `op_a`. A signed divide by zero gives LO = 0xFFFFFFFF for a non-negative dividend and LO = 1 for a negative one, with HI = `op_a`.
- R9: While `busy` is high, every command is ignored. HI and LO do not change until the running operation completes, and `result` is zero, including during a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command: 0 idle, 1 read LO, 2 read HI, 3 write LO, 4 write HI, 5 multiply, 6 unsigned divide, 7 signed divide |
| op_a | input | 32 | First operand: multiplicand, dividend or write data |
| op_b | input | 32 | Second operand: multiplier or divisor |
| mul_signed | input | 1 | Multiply treats its operands as two's complement when 1 |
| busy | output | 1 | High while a multiply or divide is in progress |
| result | output | 32 | HI or LO during a read, otherwise zero |

## Verification
The hardest situation to reach is a command that arrives while an iteration is in flight. Whether it is ignored can only be seen by reading HI and LO after the operation ends. The stimulus issues a multiply and then, on the following cycles, issues writes to both registers, a divide with different operands and a flipped `mul_signed`. The product read back afterwards must reflect only the first command. The sign corners are exercised deliberately, because the sign correction around the unsigned core is where mistakes stay hidden: mixed-sign and most-negative operands, and divide by zero with dividends of both signs.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cmd,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         mul_signed,
  output logic         busy,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [2:0] C_RDLO = 3'd1, C_RDHI = 3'd2, C_WRLO = 3'd3,
                         C_WRHI = 3'd4, C_MUL  = 3'd5, C_SDIV = 3'd7;

  logic [W-1:0]   hi, lo, dvs;
  logic [2*W-1:0] acc;
  logic [CW-1:0]  cnt;
  logic           is_div, neg_lo, neg_hi;

  assign busy = (cnt != '0);

  wire           sgn   = (cmd == C_SDIV) || (cmd == C_MUL && mul_signed);
  wire [W-1:0]   abs_a = (sgn && op_a[W-1]) ? -op_a : op_a;
  wire [W-1:0]   abs_b = (sgn && op_b[W-1]) ? -op_b : op_b;

  wire [W:0]     msum   = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, dvs} : '0);
  wire [2*W-1:0] mul_nx = {msum, acc[W-1:1]};

  wire [W+1:0]   dtry   = {1'b0, acc[2*W-1:W-1]} - {2'b00, dvs};
  wire [2*W-1:0] div_nx = dtry[W+1] ? {acc[2*W-2:0], 1'b0}
                                    : {dtry[W-1:0], acc[W-2:0], 1'b1};

  wire [2*W-1:0] step_nx = is_div ? div_nx : mul_nx;
  wire [2*W-1:0] prod    = neg_lo ? -step_nx : step_nx;
  wire [W-1:0]   quo     = neg_lo ? -step_nx[W-1:0] : step_nx[W-1:0];
  wire [W-1:0]   rem     = neg_hi ? -step_nx[2*W-1:W] : step_nx[2*W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi     <= '0;
      lo     <= '0;
      acc    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      is_div <= 1'b0;
      neg_lo <= 1'b0;
      neg_hi <= 1'b0;
    end else if (busy) begin
      acc <= step_nx;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        hi <= is_div ? rem : prod[2*W-1:W];
        lo <= is_div ? quo : prod[W-1:0];
      end
    end else begin
      case (cmd)
        C_WRLO: lo <= op_a;
        C_WRHI: hi <= op_a;
        default: ;
      endcase
      if (cmd >= C_MUL) begin
        acc    <= {{W{1'b0}}, abs_a};
        dvs    <= abs_b;
        cnt    <= CW'(W);
        is_div <= (cmd != C_MUL);
        neg_lo <= sgn && (op_a[W-1] ^ op_b[W-1]);
        neg_hi <= (cmd == C_SDIV) && op_a[W-1];
      end
    end
  end

  assign result = busy             ? '0 :
                  (cmd == C_RDLO)  ? lo :
                  (cmd == C_RDHI)  ? hi : '0;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   cmd,
  input logic [W-1:0] op_a,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         busy,
  input logic [W-1:0] result
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd >= 3'd5) |=> busy);

  // R4
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 8'd32);

  // R2
  write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'd3) |=> lo == $past(op_a));

  // R2
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'd4) |=> hi == $past(op_a));

  // R9
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy ##1 busy) |-> ($stable(hi) && $stable(lo)));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> result == '0);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (.*);

// File: tb/test_hilo_muldiv.sv
module test_hilo_muldiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        mul_signed = 1'b0;
  logic        busy;
  logic [31:0] result;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  int m_cnt = 0;

  hilo_muldiv i_hilo_muldiv (.clk(clk), .rst_n(rst_n), .cmd(cmd), .op_a(op_a),
    .op_b(op_b), .mul_signed(mul_signed), .busy(busy), .result(result));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cyc(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                     input bit s, input string tag);
    logic [31:0] exp_res;
    logic [63:0] p;
    longint sa, sb, q, r;
    cmd = c; op_a = a; op_b = b; mul_signed = s;
    #1;
    exp_res = (m_cnt != 0) ? 32'd0 : (c == 3'd1) ? m_lo : (c == 3'd2) ? m_hi : 32'd0;
    chk({tag, " busy"}, {31'd0, busy}, {31'd0, (m_cnt != 0)});
    chk({tag, " result"}, result, exp_res);
    if (m_cnt == 0) begin
      case (c)
        3'd3: m_lo = a;
        3'd4: m_hi = a;
        3'd5: begin
          if (s) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
          else   p = {32'd0, a} * {32'd0, b};
          p_hi = p[63:32]; p_lo = p[31:0]; m_cnt = 32;
        end
        3'd6: begin
          if (b == 0) begin p_lo = 32'hFFFFFFFF; p_hi = a; end
          else begin p_lo = a / b; p_hi = a % b; end
          m_cnt = 32;
        end
        3'd7: begin
          if (b == 0) begin p_lo = a[31] ? 32'd1 : 32'hFFFFFFFF; p_hi = a; end
          else begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
            q = sa / sb; r = sa % sb;
            p_lo = q[31:0]; p_hi = r[31:0];
          end
          m_cnt = 32;
        end
        default: ;
      endcase
    end else begin
      m_cnt--;
      if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                        input bit s, input string tag);
    cyc(c, a, b, s, tag);
    repeat (32) cyc(3'd1, 32'h0, 32'h0, 1'b0, tag);
    cyc(3'd1, 32'h0, 32'h0, 1'b0, tag);
    cyc(3'd2, 32'h0, 32'h0, 1'b0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset result", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(3'd1, 0, 0, 0, "R1");
    cyc(3'd2, 0, 0, 0, "R1");

    cyc(3'd3, 32'h12345678, 32'h0, 0, "R2");
    cyc(3'd4, 32'hCAFEF00D, 32'h0, 0, "R2");
    cyc(3'd1, 0, 0, 0, "R3");
    cyc(3'd2, 0, 0, 0, "R3");
    cyc(3'd0, 0, 0, 0, "R3");
    cyc(3'd4, 32'h0BADBEEF, 0, 0, "R3");
    cyc(3'd2, 0, 0, 0, "R3");

    run_op(3'd5, 32'd3, 32'd5, 0, "R4");
    run_op(3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R5");
    run_op(3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, "R5");
    run_op(3'd5, -32'sd3, 32'd7, 1, "R5");
    run_op(3'd5, 32'h80000000, 32'h80000000, 1, "R5");
    run_op(3'd5, 32'h80000000, 32'h7FFFFFFF, 1, "R5");

    run_op(3'd6, 32'd100, 32'd7, 0, "R6");
    run_op(3'd6, 32'hFFFFFFFF, 32'h10, 0, "R6");
    run_op(3'd6, 32'd5, 32'd9, 0, "R6");
    run_op(3'd6, 32'h80000000, 32'hFFFFFFFF, 0, "R6");

    run_op(3'd7, -32'sd100, 32'd7, 0, "R7");
    run_op(3'd7, 32'd100, -32'sd7, 0, "R7");
    run_op(3'd7, -32'sd100, -32'sd7, 0, "R7");
    run_op(3'd7, 32'h80000000, 32'hFFFFFFFF, 0, "R7");

    run_op(3'd6, 32'h00001234, 32'd0, 0, "R8");
    run_op(3'd7, 32'h00001234, 32'd0, 0, "R8");
    run_op(3'd7, 32'hFFFF0000, 32'd0, 0, "R8");

    cyc(3'd5, 32'd1000, 32'd1000, 0, "R9");
    cyc(3'd3, 32'h11111111, 0, 0, "R9");
    cyc(3'd4, 32'h22222222, 0, 1, "R9");
    cyc(3'd7, 32'd50, 32'd3, 1, "R9");
    cyc(3'd5, 32'hFFFFFFFF, 32'd2, 1, "R9");
    cyc(3'd2, 0, 0, 0, "R9");
    repeat (27) cyc(3'd0, 32'h33333333, 32'h44444444, 1, "R9");
    cyc(3'd1, 0, 0, 0, "R9");
    cyc(3'd2, 0, 0, 0, "R9");
    cyc(3'd3, 32'h55555555, 0, 0, "R2");
    cyc(3'd1, 0, 0, 0, "R2");

    finish_run();
  end
endmodule